// File: doc/BRIEF.md
# Parallel Flash Bus Cycle Generator

This block sits on the host side of an asynchronous parallel NOR-style flash bus and turns single-word read and write requests into correctly timed bus cycles. It drives a latched address, split data-out/data-in pads with an output-enable for the data driver, and active-low chip-enable, output-enable and write-enable strobes. All flash timing minimums are given as nanosecond parameters; together with the clock period, each is converted at elaboration time into a whole number of clock cycles. The conversion rounds up and never yields fewer than one cycle.

A write is built from an ordered run of phases. Chip-enable falls first. Write-enable then goes low for a pulse long enough to cover both the minimum pulse width and the address/data setup time before its rising edge. After that comes a hold phase with chip-enable, address and data kept, and then a recovery phase that stretches the cycle to the minimum cycle time and the minimum write-enable high time. A read lowers chip-enable and output-enable together with a fresh address. The read data is sampled after the longest of the three access times, and a short recovery phase follows. After a read, a turnaround counter keeps the host off the data bus until the flash has released it.

The requester sees a simple handshake. A request is taken on a clock edge where `ready_o` is high. `ready_o` stays low until the operation completes, and a one-cycle `done_o` marks completion and carries the read data.

Top module: `nor_cycle_gen`

## Requirements
- R1: While reset is asserted, all three strobes are high, the data driver is off, `ready_o` is 1 and `done_o` is 0.
- R2: A request is accepted only on an edge where `ready_o` is high. `ready_o` is low from the edge after acceptance until the operation ends. `done_o` is high for exactly one cycle (the final recovery cycle), and `ready_o` is high in the cycle after it.
- R3: In a write, chip-enable is low and the host drives address and data for ceil(10 ns / period) cycles (3 at 4 ns) before write-enable falls.
- R4: Write-enable stays low for max(ceil(50 ns pulse), ceil(50 ns setup)) cycles (13 at 4 ns), with address and data unchanged.
- R5: After write-enable rises, chip-enable, address and data drive are held for max(ceil(5 ns), ceil(10 ns)) cycles (3 at 4 ns). Chip-enable then rises and the driver turns off.
- R6: Write recovery lasts max(1, ceil(30 ns) − hold, ceil(cycle time) − setup − pulse − hold) cycles (6 at 4 ns with a 100 ns cycle), and `done_o` is asserted in its last cycle.
- R7: A read lowers chip-enable and output-enable in the acceptance cycle with the new address and keeps them low for max(ceil(100 ns), ceil(100 ns), ceil(45 ns)) cycles (25 at 4 ns). Write-enable stays high. The data input is sampled at the edge ending that window and returned on `rdata_o` while `done_o` is high.
- R8: Read recovery lasts max(1, ceil(cycle time) − access) cycles (1 at defaults), with all strobes high.
- R9: After a read, the first write phase starts at the later of the acceptance edge and the (REL+1)th edge after output-enable rises, where REL = max(ceil(20 ns), ceil(50 ns)) = 13. Until then the strobes stay high and the driver stays off.
- R10: The host data driver is never on while output-enable is low.
- R11: A request raised while `ready_o` is low is ignored. The running cycle, its address and its data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Operation request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Request address |
| wdata_i | input | DW | Write data |
| ready_o | output | 1 | Idle and able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Read data, valid with done_o on reads |
| flash_addr_o | output | AW | Flash address bus |
| flash_dq_o | output | DW | Data driven toward the flash |
| flash_dq_oe_o | output | 1 | Enable for the host data driver |
| flash_dq_i | input | DW | Data from the flash pads |
| flash_ce_no | output | 1 | Chip-enable, active low |
| flash_oe_no | output | 1 | Output-enable, active low |
| flash_we_no | output | 1 | Write-enable, active low |

## Verification
The assertions assume that the request inputs matter only on the accepting edge. They also assume that nothing other than the flash and this block drives the data pads, so a release window measured from the output-enable rise is enough to prevent contention. The bench changes every input on the falling clock edge. It models the flash so that data becomes valid exactly when the access window has elapsed and reads as garbage before then, which means an early sample is visible at `rdata_o`. It raises spurious requests only while `ready_o` is low, and drops them on the falling edge that first shows `ready_o` high.

// File: rtl/nor_cyc_pkg.sv
package nor_cyc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WWAIT,
    PH_WSU,
    PH_WLO,
    PH_WHO,
    PH_WRC,
    PH_RACC,
    PH_RRC
  } phase_e;

  function automatic int ns2cyc(int ns, int per);
    int c;
    c = (ns + per - 1) / per;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nor_phase_timer.sv
module nor_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i - CW'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign last_o = (cnt_q == '0);

  // every phase lasts at least one cycle
  p_len_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0));

endmodule

// File: rtl/nor_turnaround.sv
module nor_turnaround #(
  parameter int CW  = 5,
  parameter int REL = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic ok_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (arm_i)       cnt_q <= CW'(REL);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign ok_o = (cnt_q == '0);

  p_arm_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !ok_o);

endmodule

// File: rtl/nor_cycle_seq.sv
module nor_cycle_seq
  import nor_cyc_pkg::*;
#(
  parameter int CW   = 5,
  parameter int L_SU = 3,
  parameter int L_LO = 13,
  parameter int L_HO = 3,
  parameter int L_RC = 6,
  parameter int L_AC = 25,
  parameter int L_RR = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          rel_ok_i,
  input  logic          tmr_last_i,
  output phase_e        phase_o,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_len_o,
  output logic          accept_o,
  output logic          arm_o,
  output logic          capture_o,
  output logic          done_o
);
  phase_e ph_q, ph_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  always_comb begin
    ph_d       = ph_q;
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    accept_o   = 1'b0;
    arm_o      = 1'b0;
    capture_o  = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (req_i) begin
        accept_o = 1'b1;
        if (we_i) begin
          if (rel_ok_i) begin
            ph_d = PH_WSU; tmr_load_o = 1'b1; tmr_len_o = CW'(L_SU);
          end else begin
            ph_d = PH_WWAIT;
          end
        end else begin
          ph_d = PH_RACC; tmr_load_o = 1'b1; tmr_len_o = CW'(L_AC);
        end
      end
      PH_WWAIT: if (rel_ok_i) begin
        ph_d = PH_WSU; tmr_load_o = 1'b1; tmr_len_o = CW'(L_SU);
      end
      PH_WSU: if (tmr_last_i) begin
        ph_d = PH_WLO; tmr_load_o = 1'b1; tmr_len_o = CW'(L_LO);
      end
      PH_WLO: if (tmr_last_i) begin
        ph_d = PH_WHO; tmr_load_o = 1'b1; tmr_len_o = CW'(L_HO);
      end
      PH_WHO: if (tmr_last_i) begin
        ph_d = PH_WRC; tmr_load_o = 1'b1; tmr_len_o = CW'(L_RC);
      end
      PH_WRC: if (tmr_last_i) ph_d = PH_IDLE;
      PH_RACC: if (tmr_last_i) begin
        ph_d = PH_RRC; tmr_load_o = 1'b1; tmr_len_o = CW'(L_RR);
        arm_o = 1'b1; capture_o = 1'b1;
      end
      PH_RRC: if (tmr_last_i) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  assign phase_o = ph_q;
  assign done_o  = ((ph_q == PH_WRC) || (ph_q == PH_RRC)) && tmr_last_i;

  p_wait_only_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WWAIT) |-> !rel_ok_i || (ph_d == PH_WSU));

endmodule

// File: rtl/nor_cycle_gen.sv
module nor_cycle_gen
  import nor_cyc_pkg::*;
#(
  parameter int AW              = 21,
  parameter int DW              = 16,
  parameter int CLK_PERIOD_NS   = 4,
  parameter int T_CE_SETUP_NS   = 10,
  parameter int T_WE_LOW_NS     = 50,
  parameter int T_WE_HIGH_NS    = 30,
  parameter int T_WR_SETUP_NS   = 50,
  parameter int T_WR_HOLD_NS    = 5,
  parameter int T_CE_HOLD_NS    = 10,
  parameter int T_CYCLE_NS      = 100,
  parameter int T_ADDR_ACC_NS   = 100,
  parameter int T_CE_ACC_NS     = 100,
  parameter int T_OE_ACC_NS     = 45,
  parameter int T_OE_REL_NS     = 20,
  parameter int T_CE_REL_NS     = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] flash_addr_o,
  output logic [DW-1:0] flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic [DW-1:0] flash_dq_i,
  output logic          flash_ce_no,
  output logic          flash_oe_no,
  output logic          flash_we_no
);
  localparam int P     = CLK_PERIOD_NS;
  localparam int L_SU  = ns2cyc(T_CE_SETUP_NS, P);
  localparam int L_LO  = imax(ns2cyc(T_WE_LOW_NS, P), ns2cyc(T_WR_SETUP_NS, P));
  localparam int L_HO  = imax(ns2cyc(T_WR_HOLD_NS, P), ns2cyc(T_CE_HOLD_NS, P));
  localparam int L_CY  = ns2cyc(T_CYCLE_NS, P);
  localparam int L_RC  = imax(1, imax(ns2cyc(T_WE_HIGH_NS, P) - L_HO,
                                      L_CY - (L_SU + L_LO + L_HO)));
  localparam int L_AC  = imax(ns2cyc(T_ADDR_ACC_NS, P),
                              imax(ns2cyc(T_CE_ACC_NS, P), ns2cyc(T_OE_ACC_NS, P)));
  localparam int L_RR  = imax(1, L_CY - L_AC);
  localparam int L_REL = imax(ns2cyc(T_OE_REL_NS, P), ns2cyc(T_CE_REL_NS, P));
  localparam int L_MAX = imax(imax(imax(L_SU, L_LO), imax(L_HO, L_RC)),
                              imax(imax(L_AC, L_RR), L_REL));
  localparam int CW    = $clog2(L_MAX + 1);

  phase_e        phase;
  logic          tmr_load, tmr_last, accept, arm, capture, rel_ok;
  logic [CW-1:0] tmr_len;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  nor_cycle_seq #(
    .CW(CW), .L_SU(L_SU), .L_LO(L_LO), .L_HO(L_HO),
    .L_RC(L_RC), .L_AC(L_AC), .L_RR(L_RR)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .rel_ok_i   (rel_ok),
    .tmr_last_i (tmr_last),
    .phase_o    (phase),
    .tmr_load_o (tmr_load),
    .tmr_len_o  (tmr_len),
    .accept_o   (accept),
    .arm_o      (arm),
    .capture_o  (capture),
    .done_o     (done_o)
  );

  nor_phase_timer #(.CW(CW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .last_o (tmr_last)
  );

  nor_turnaround #(.CW(CW), .REL(L_REL)) u_turn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .ok_o   (rel_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (capture) rdata_q <= flash_dq_i;
  end

  assign ready_o       = (phase == PH_IDLE);
  assign rdata_o       = rdata_q;
  assign flash_addr_o  = addr_q;
  assign flash_dq_o    = wdata_q;
  assign flash_dq_oe_o = (phase == PH_WSU) || (phase == PH_WLO) || (phase == PH_WHO);
  assign flash_ce_no   = !((phase == PH_WSU) || (phase == PH_WLO) ||
                           (phase == PH_WHO) || (phase == PH_RACC));
  assign flash_oe_no   = (phase != PH_RACC);
  assign flash_we_no   = (phase != PH_WLO);

  p_ce_before_we_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flash_we_no) |-> $past(!flash_ce_no));

  p_ce_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_we_no) |-> !flash_ce_no && flash_dq_oe_o);

  p_addr_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no && $past(!flash_we_no)) |-> $stable(flash_addr_o) && $stable(flash_dq_o));

  p_oe_with_ce_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_oe_no |-> !flash_ce_no && flash_we_no);

  p_no_contention_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_oe_no |-> !flash_dq_oe_o);

  p_drive_after_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_dq_oe_o) |-> rel_ok);

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && ready_o);

  p_busy_no_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !done_o) |=> $stable(flash_addr_o));

endmodule

// File: tb/nor_cycle_gen_test.sv
module nor_cycle_gen_test;
  localparam int AW = 21;
  localparam int DW = 16;

  function automatic int cy(int ns);
    int c;
    c = (ns + 3) / 4;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int W_SU = cy(10);
  localparam int W_LO = mx(cy(50), cy(50));
  localparam int W_HO = mx(cy(5), cy(10));
  localparam int W_RC = mx(1, mx(cy(30) - W_HO, cy(100) - (W_SU + W_LO + W_HO)));
  localparam int W_TOT = W_SU + W_LO + W_HO + W_RC;
  localparam int R_AC = mx(cy(100), mx(cy(100), cy(45)));
  localparam int R_RC = mx(1, cy(100) - R_AC);
  localparam int R_TOT = R_AC + R_RC;
  localparam int REL  = mx(cy(20), cy(50));

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic ready_o, done_o, flash_dq_oe_o, flash_ce_no, flash_oe_no, flash_we_no;
  logic [DW-1:0] rdata_o, flash_dq_o;
  logic [DW-1:0] flash_dq_i = '0;
  logic [AW-1:0] flash_addr_o;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  nor_cycle_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .done_o(done_o),
    .rdata_o(rdata_o), .flash_addr_o(flash_addr_o), .flash_dq_o(flash_dq_o),
    .flash_dq_oe_o(flash_dq_oe_o), .flash_dq_i(flash_dq_i),
    .flash_ce_no(flash_ce_no), .flash_oe_no(flash_oe_no), .flash_we_no(flash_we_no)
  );

  function automatic logic [DW-1:0] fval(logic [AW-1:0] a);
    return a[DW-1:0] ^ 16'h5A3C;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // flash model: data valid only once output-enable has been low R_AC cycles
  int olc = 0;
  always @(negedge clk) begin
    if (!flash_oe_no && !flash_ce_no) olc++; else olc = 0;
    flash_dq_i <= (olc >= R_AC) ? fval(flash_addr_o) : 16'hDEAD;
  end

  // reference model
  int n = 0, mstart = 0, rel_ready = 0;
  bit mbusy = 0, mwe = 0;
  logic [AW-1:0] ma = '0;
  logic [DW-1:0] md = '0;

  always @(posedge clk) if (rst_ni) begin
    n++;
    if (mbusy && (n - mstart == (mwe ? W_TOT : R_TOT))) mbusy = 0;
    else if (!mbusy && req_i) begin
      mbusy = 1; mwe = we_i; ma = addr_i; md = wdata_i;
      if (we_i) mstart = mx(n, rel_ready);
      else begin
        mstart = n;
        rel_ready = n + R_AC + REL + 1;
      end
    end
  end

  always @(negedge clk) if (rst_ni && n > 0) begin
    logic [5:0] ev, av;
    string tag;
    int off;
    ev = 6'b111_0_1_0; // ce oe we dqoe rdy done
    tag = "R2";
    if (mbusy) begin
      ev[1] = 1'b0;
      off = n - mstart;
      if (mwe) begin
        if (off < 0) tag = "R9";
        else if (off < W_SU) begin ev[5] = 0; ev[2] = 1; tag = "R3"; end
        else if (off < W_SU + W_LO) begin ev[5] = 0; ev[3] = 0; ev[2] = 1; tag = "R4"; end
        else if (off < W_SU + W_LO + W_HO) begin ev[5] = 0; ev[2] = 1; tag = "R5"; end
        else tag = "R6";
        ev[0] = (off == W_TOT - 1);
      end else begin
        if (off < R_AC) begin ev[5] = 0; ev[4] = 0; tag = "R7"; end
        else tag = "R8";
        ev[0] = (off == R_TOT - 1);
      end
      if (req_i) tag = "R11";
    end
    av = {flash_ce_no, flash_oe_no, flash_we_no, flash_dq_oe_o, ready_o, done_o};
    check(av == ev, tag, 32'(av), 32'(ev));
    if (mbusy) check(flash_addr_o == ma, tag, 32'(flash_addr_o), 32'(ma));
    if (ev[2]) check(flash_dq_o == md, tag, 32'(flash_dq_o), 32'(md));
    if (ev[0] && !mwe) check(rdata_o == fval(ma), "R7", 32'(rdata_o), 32'(fval(ma)));
    if (!flash_oe_no) check(!flash_dq_oe_o, "R10", 32'(flash_dq_oe_o), 32'd0);
  end

  task automatic issue(bit w, logic [AW-1:0] a, logic [DW-1:0] d, bit junk);
    while (!ready_o) @(negedge clk);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
    if (junk) begin
      while (!ready_o) begin
        req_i = 1'b1; we_i = ~w; addr_i = ~a; wdata_i = ~d;
        @(negedge clk);
      end
      req_i = 1'b0;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({flash_ce_no, flash_oe_no, flash_we_no, flash_dq_oe_o, ready_o, done_o} == 6'b111010,
          "R1", 32'({flash_ce_no, flash_oe_no, flash_we_no, flash_dq_oe_o, ready_o, done_o}),
          32'h3A);
    rst_ni = 1'b1;
    @(negedge clk);
    issue(1'b1, 21'h00123, 16'hBEEF, 1'b0);    // plain write
    issue(1'b1, 21'h1FFFF, 16'h0001, 1'b0);    // back-to-back write, R6 recovery
    issue(1'b0, 21'h00123, 16'h0000, 1'b0);    // read
    issue(1'b1, 21'h00456, 16'hA55A, 1'b0);    // write right after read, R9 wait
    issue(1'b0, 21'h0ABCD, 16'h0000, 1'b1);    // read with junk requests, R11
    issue(1'b0, 21'h10000, 16'h0000, 1'b0);    // back-to-back reads, R8
    issue(1'b1, 21'h07777, 16'hFFFF, 1'b1);    // write with junk requests, R11
    issue(1'b0, 21'h00001, 16'h0000, 1'b0);
    while (!ready_o) @(negedge clk);
    repeat (REL + 4) @(negedge clk);
    issue(1'b1, 21'h00002, 16'h1234, 1'b0);    // write long after read: no wait
    while (!ready_o) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule